// File: doc/BRIEF.md
# Processor Status Word and Stack Selector

This block keeps the 16-bit status word of a processor core and tells the register file which copy of the stack pointer (A7) is live. The high byte holds the system state: a supervisor bit and a 3-bit interrupt mask. The low byte holds the arithmetic flags. These are carry, overflow, zero, negative and a separate extend flag, which multiword arithmetic uses to chain a carry without disturbing the ordinary carry.

The status word changes in four ways. The ALU can update any chosen subset of flags. A flag-only write loads the low byte and needs no privilege. A whole-word write loads both bytes, but only when the requester is in supervisor state. A user-state attempt is dropped and flagged by a one-cycle violation pulse. An exception entry always forces supervisor state, and for an interrupt it also loads the new mask level. Every port is a plain control or status pin. No port is a stream, so there is no back-pressure. Each request is taken in the cycle it is presented.

Top module: `psw_ctl`

## Requirements
- R1: After reset the status word reads 0x2700 (supervisor set, mask 7, flags clear), `a7_super_o` is 1 and `priv_viol_o` is 0.
- R2: Bit layout of `sr_o`: C bit 0, V bit 1, Z bit 2, N bit 3, X bit 4, interrupt mask bits 10:8, supervisor bit 13. All other bits always read 0, even after writing ones to them.
- R3: A whole-word write with `wr_super_i`=1 loads the supervisor bit, mask and flags from `wr_data_i`. The new value appears on `sr_o` after the next rising edge.
- R4: A whole-word write with `wr_super_i`=0 changes no bit of the status word. `priv_viol_o` is high for exactly the one cycle after that edge and is low at all other times.
- R5: A flag-only write, in either privilege state, loads bits 4:0 from `wr_data_i[4:0]` and leaves the system byte unchanged.
- R6: An ALU update writes `alu_flags_i[i]` into flag i only where `alu_en_i[i]` is 1, using the same bit order as R2. Flags that are not enabled hold their value, so X and C can be set independently.
- R7: An exception entry sets the supervisor bit and leaves the flags unchanged. If `exc_irq_i` is 1 the mask takes `exc_level_i`; otherwise the mask holds.
- R8: Priority: an exception entry overrides a whole-word write for the system byte. For the flags, a whole-word write comes first, then a flag-only write, then the ALU update.
- R9: `a7_super_o` equals the current supervisor bit: 1 selects the supervisor stack pointer and 0 selects the user stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_upd_i | input | 1 | ALU flag update strobe |
| alu_en_i | input | 5 | Per-flag update enable (bit order of R2) |
| alu_flags_i | input | 5 | New flag values from the ALU |
| wr_word_i | input | 1 | Whole-word write request |
| wr_flags_i | input | 1 | Flag-only write request |
| wr_super_i | input | 1 | Privilege state of the requester (1 = supervisor) |
| wr_data_i | input | 16 | Write data |
| exc_i | input | 1 | Exception entry strobe |
| exc_irq_i | input | 1 | Exception is an interrupt; load the mask |
| exc_level_i | input | 3 | Interrupt level for the mask |
| sr_o | output | 16 | Status word |
| priv_viol_o | output | 1 | Privilege violation pulse |
| a7_super_o | output | 1 | Stack pointer select (1 = supervisor copy) |

## Verification
The assertions check the following on every cycle:
- Every user-state word write raises the violation pulse, and the pulse never appears without one.
- A refused write leaves the system byte untouched.
- An exception entry always lands in supervisor state.
- Flags whose ALU enable is clear hold their value.
- A flag-only write loads the low byte.

Only the bench scenarios show the actual encoded values. These include the reset word, zeros in the unused bits, the stack select following the supervisor bit, and the outcome of competing requests in the same cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int SR_W     = 16;
  localparam int FLAG_N   = 5;
  localparam int MASK_W   = 3;
  localparam int C_POS    = 0;
  localparam int V_POS    = 1;
  localparam int Z_POS    = 2;
  localparam int N_POS    = 3;
  localparam int X_POS    = 4;
  localparam int MASK_LSB = 8;
  localparam int MASK_MSB = MASK_LSB + MASK_W - 1;
  localparam int SUP_POS  = 13;
  localparam logic [MASK_W-1:0] MASK_RST = '1;
endpackage

// File: rtl/psw_flags.sv
module psw_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_we,
  input  logic         flag_we,
  input  logic [N-1:0] wr_val,
  input  logic         alu_we,
  input  logic [N-1:0] alu_en,
  input  logic [N-1:0] alu_val,
  output logic [N-1:0] flags_q
);
  logic any_wr;
  assign any_wr = word_we | flag_we;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flags_q[i] <= 1'b0;
      else if (any_wr)            flags_q[i] <= wr_val[i];
      else if (alu_we && alu_en[i]) flags_q[i] <= alu_val[i];
    end

    // R6: a flag with its enable clear is not touched by the ALU
    a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_wr && !(alu_we && alu_en[i])) |=> $stable(flags_q[i]));
  end

  // R5: a flag-only write lands in the flag byte
  a_r5_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !word_we) |=> (flags_q == $past(wr_val)));
endmodule

// File: rtl/psw_sys.sv
module psw_sys #(
  parameter int MW = 3,
  parameter logic [MW-1:0] MASK_INIT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_req,
  input  logic          req_super,
  input  logic          sup_val,
  input  logic [MW-1:0] mask_val,
  input  logic          exc,
  input  logic          exc_irq,
  input  logic [MW-1:0] exc_lvl,
  output logic          sup_q,
  output logic [MW-1:0] mask_q,
  output logic          viol_q,
  output logic          word_ok
);
  logic refused;
  assign word_ok = word_req & req_super;
  assign refused = word_req & ~req_super;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q  <= 1'b1;
      mask_q <= MASK_INIT;
      viol_q <= 1'b0;
    end else begin
      viol_q <= refused;
      if (exc) begin
        sup_q <= 1'b1;
        if (exc_irq) mask_q <= exc_lvl;
      end else if (word_ok) begin
        sup_q  <= sup_val;
        mask_q <= mask_val;
      end
    end
  end

  // R4: every refused write raises the violation pulse
  a_r4_viol_raise: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> viol_q);
  // R4: no violation pulse without a refused write
  a_r4_viol_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !refused |=> !viol_q);
  // R4: a refused write leaves the system byte unchanged
  a_r4_sys_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (refused && !exc) |=> ($stable(sup_q) && $stable(mask_q)));
  // R7: exception entry always ends in supervisor state
  a_r7_exc_super: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> sup_q);
endmodule

// File: rtl/psw_ctl.sv
module psw_ctl
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_upd_i,
  input  logic [FLAG_N-1:0] alu_en_i,
  input  logic [FLAG_N-1:0] alu_flags_i,
  input  logic              wr_word_i,
  input  logic              wr_flags_i,
  input  logic              wr_super_i,
  input  logic [SR_W-1:0]   wr_data_i,
  input  logic              exc_i,
  input  logic              exc_irq_i,
  input  logic [MASK_W-1:0] exc_level_i,
  output logic [SR_W-1:0]   sr_o,
  output logic              priv_viol_o,
  output logic              a7_super_o
);
  logic              sup_q;
  logic [MASK_W-1:0] mask_q;
  logic [FLAG_N-1:0] flags_q;
  logic              word_ok;

  psw_sys #(.MW(MASK_W), .MASK_INIT(MASK_RST)) u_sys (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_req (wr_word_i),
    .req_super(wr_super_i),
    .sup_val  (wr_data_i[SUP_POS]),
    .mask_val (wr_data_i[MASK_MSB:MASK_LSB]),
    .exc      (exc_i),
    .exc_irq  (exc_irq_i),
    .exc_lvl  (exc_level_i),
    .sup_q    (sup_q),
    .mask_q   (mask_q),
    .viol_q   (priv_viol_o),
    .word_ok  (word_ok)
  );

  psw_flags #(.N(FLAG_N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .word_we(word_ok),
    .flag_we(wr_flags_i),
    .wr_val (wr_data_i[FLAG_N-1:0]),
    .alu_we (alu_upd_i),
    .alu_en (alu_en_i),
    .alu_val(alu_flags_i),
    .flags_q(flags_q)
  );

  always_comb begin
    sr_o                     = '0;
    sr_o[FLAG_N-1:0]         = flags_q;
    sr_o[MASK_MSB:MASK_LSB]  = mask_q;
    sr_o[SUP_POS]            = sup_q;
  end

  assign a7_super_o = sup_q;
endmodule

// File: tb/tb_psw_ctl.sv
module tb_psw_ctl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        alu_upd_i = 0;
  logic [4:0]  alu_en_i = 0, alu_flags_i = 0;
  logic        wr_word_i = 0, wr_flags_i = 0, wr_super_i = 0;
  logic [15:0] wr_data_i = 0;
  logic        exc_i = 0, exc_irq_i = 0;
  logic [2:0]  exc_level_i = 0;
  logic [15:0] sr_o;
  logic        priv_viol_o, a7_super_o;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  psw_ctl dut (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    alu_upd_i = 0; alu_en_i = 0; alu_flags_i = 0;
    wr_word_i = 0; wr_flags_i = 0; wr_super_i = 0; wr_data_i = 0;
    exc_i = 0; exc_irq_i = 0; exc_level_i = 0;
  endtask

  // inputs held across one rising edge, outputs sampled at the following falling edge
  task automatic commit();
    @(negedge clk);
    idle();
  endtask

  task automatic word_wr(input logic sup, input logic [15:0] d);
    @(negedge clk); wr_word_i = 1; wr_super_i = sup; wr_data_i = d;
    commit();
  endtask

  task automatic t_reset();
    chk("R1 sr", sr_o, 16'h2700);
    chk("R1 sel", {15'd0, a7_super_o}, 16'd1);
    chk("R1 viol", {15'd0, priv_viol_o}, 16'd0);
  endtask

  task automatic t_super_write();
    word_wr(1, 16'hFFFF);
    chk("R2 R3 unused bits zero", sr_o, 16'h271F);
    word_wr(1, 16'h0005);
    chk("R3 load", sr_o, 16'h0005);
    chk("R9 user stack", {15'd0, a7_super_o}, 16'd0);
  endtask

  task automatic t_user_write();
    word_wr(0, 16'h2700);
    chk("R4 no change", sr_o, 16'h0005);
    chk("R4 pulse", {15'd0, priv_viol_o}, 16'd1);
    @(negedge clk);
    chk("R4 pulse ends", {15'd0, priv_viol_o}, 16'd0);
  endtask

  task automatic t_flag_write();
    @(negedge clk); wr_flags_i = 1; wr_super_i = 0; wr_data_i = 16'hFF1A;
    commit();
    chk("R5 flag write in user state", sr_o, 16'h001A);
  endtask

  task automatic t_alu();
    @(negedge clk); alu_upd_i = 1; alu_en_i = 5'h01; alu_flags_i = 5'h01;
    commit();
    chk("R6 C only, X kept", sr_o, 16'h001B);
    @(negedge clk); alu_upd_i = 1; alu_en_i = 5'h11; alu_flags_i = 5'h00;
    commit();
    chk("R6 X and C cleared", sr_o, 16'h000A);
    @(negedge clk); alu_upd_i = 1; alu_en_i = 5'h0E; alu_flags_i = 5'h04;
    commit();
    chk("R6 NZV", sr_o, 16'h0004);
  endtask

  task automatic t_exc();
    @(negedge clk); exc_i = 1; exc_irq_i = 1; exc_level_i = 3'd5;
    commit();
    chk("R7 irq entry", sr_o, 16'h2504);
    chk("R9 super stack", {15'd0, a7_super_o}, 16'd1);
    word_wr(1, 16'h0000);
    @(negedge clk); exc_i = 1; exc_irq_i = 0; exc_level_i = 3'd6;
    commit();
    chk("R7 trap keeps mask", sr_o, 16'h2000);
  endtask

  task automatic t_prio();
    @(negedge clk); exc_i = 1; exc_irq_i = 1; exc_level_i = 3'd3;
    wr_word_i = 1; wr_super_i = 1; wr_data_i = 16'h0712;
    commit();
    chk("R8 exception beats word write", sr_o, 16'h2312);
    @(negedge clk); wr_flags_i = 1; wr_data_i = 16'h0001;
    alu_upd_i = 1; alu_en_i = 5'h1F; alu_flags_i = 5'h1E;
    commit();
    chk("R8 flag write beats ALU", sr_o, 16'h2301);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_super_write();
    t_user_write();
    t_flag_write();
    t_alu();
    t_exc();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule